// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings a bank of SDRAM rows from power-on to normal operation. After a start pulse it waits for the supply and clocks to settle. It then steps the controller through a fixed series of mode commands: NOP, precharge of all banks, eight CBR refresh commands, and a mode-register load. Each of these commands is issued once to every populated row, one row at a time, at the base address of that row. At the end the block puts the controller back in normal mode, raises a refresh-enable flag for the refresh logic downstream, and reports completion.

Rows are described by eight cumulative end boundaries in 8 MB units. The start of a row is the end of the row before it, and zero for row 0. A row whose end is not above its start is empty and gets no command. For the mode-register load, the address carries an offset that encodes the CAS latency. That offset is different for the lower four rows and the upper four rows, because the second pair of modules sees some address lines inverted. All waits are counted in microseconds, and the length of one microsecond is given as a programmable count of clock cycles.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After reset the mode output is 000 (normal), the strobe, done and refresh-enable outputs are low, and nothing happens until a start pulse arrives.
- R2: The mode output uses the codes NOP = 001, precharge-all = 010, mode-register load = 011, CBR refresh = 100 and normal = 000. The modes follow the order NOP, precharge-all, CBR repeated eight times, mode-register load, then normal. Every strobe carries one of the four non-normal codes.
- R3: Each non-normal command is strobed exactly once for every populated row, with rows visited in ascending order. Row r is populated when its end boundary (bits [8r+7:8r] of the boundary input) is strictly greater than its start, which is the end boundary of row r-1, or 0 for row 0. Empty rows receive no strobe. The row output gives the row index.
- R4: For NOP, precharge-all and CBR, the address output equals the row's start boundary multiplied by 2^23 (8 MB).
- R5: For the mode-register load, the address output is the row base plus an offset. With CAS latency 3 (latency input 0) the offset is 0x1D0 for rows 0–3 and 0x1E28 for rows 4–7. With CAS latency 2 (latency input 1) it is 0x150 for rows 0–3 and 0x1EA8 for rows 4–7.
- R6: The strobe is a single-cycle pulse, and two strobes never fall in consecutive cycles.
- R7: One microsecond is the programmed cycle count, and a count of 0 acts as 1. The block waits at least 200 µs from start to the first NOP strobe. After the last strobe of each command it waits at least 200 µs for NOP, 1 µs for precharge-all, 1 µs after each CBR round, and 2 µs for the mode-register load. The whole sequence from start to done takes at least 412 µs.
- R8: After the mode-register load wait, the mode returns to 000 with no strobe. After a further 1 µs, done and refresh-enable both go high and stay high until reset, and the mode stays 000.
- R9: A start pulse is ignored while the sequence is running and after it has completed. It neither restarts the sequence nor produces strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins the power-up sequence when idle |
| row_bound_i | input | 64 | Eight cumulative row end boundaries, 8 bits each, in 8 MB units, row 0 in the low byte |
| cas_lat2_i | input | 1 | 1 selects CAS latency 2, 0 selects CAS latency 3 |
| us_cycles_i | input | 16 | Clock cycles per microsecond |
| cmd_o | output | 3 | Current controller mode code |
| cmd_vld_o | output | 1 | One-cycle strobe that issues the current command to a row |
| row_o | output | 3 | Row addressed by the strobe |
| addr_o | output | 31 | Address of the strobe: row base plus any mode-register offset |
| done_o | output | 1 | Sequence complete; held until reset |
| refresh_en_o | output | 1 | Periodic refresh allowed; held until reset |

## Verification
A start request can arrive in the same cycle as any step of a running sequence. That includes the cycle in which a row scan finishes and the wait timer is loaded, the cycle in which a wait expires and the next mode is chosen, and the cycle in which done is raised. One directed run holds the start input high from the first cycle to the last, which puts a start request on top of every one of those transitions. It passes only if the captured strobe log still matches, entry for entry, the list computed from the boundaries, and if done stays high with no further strobes afterwards. A second check pulses start after completion and watches for a silent restart over a window longer than the power-up wait.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Controller mode codes; the encoding is seen by the command logic downstream.
    typedef enum logic [2:0] {
        MODE_NORMAL = 3'b000,
        MODE_NOP    = 3'b001,
        MODE_PRECHG = 3'b010,
        MODE_MRS    = 3'b011,
        MODE_CBR    = 3'b100
    } mode_e;

    // Phases of the sequencer.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PWR_WAIT,
        PH_SCAN,
        PH_WAIT,
        PH_NORM_WAIT,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/seq_us_timer.sv
module seq_us_timer #(
    parameter int US_W  = 8,
    parameter int CYC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [US_W-1:0]  us_i,
    input  logic [CYC_W-1:0] cyc_per_us_i,
    output logic             expired_o
);

    typedef struct packed {
        logic             busy;
        logic [US_W-1:0]  us_left;
        logic [CYC_W-1:0] cyc;
        logic             expired;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [CYC_W-1:0] last_cyc;

    // A cycle count of zero behaves like one cycle per microsecond.
    always_comb begin
        last_cyc = (cyc_per_us_i == '0) ? '0 : cyc_per_us_i - CYC_W'(1);
    end

    always_comb begin
        s_d         = s_q;
        s_d.expired = 1'b0;
        if (load_i) begin
            s_d.busy    = 1'b1;
            s_d.us_left = us_i;
            s_d.cyc     = '0;
        end else if (s_q.busy) begin
            if (s_q.cyc >= last_cyc) begin
                s_d.cyc = '0;
                if (s_q.us_left <= US_W'(1)) begin
                    s_d.busy    = 1'b0;
                    s_d.us_left = '0;
                    s_d.expired = 1'b1;
                end else begin
                    s_d.us_left = s_q.us_left - US_W'(1);
                end
            end else begin
                s_d.cyc = s_q.cyc + CYC_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign expired_o = s_q.expired;

    // R7: the controller never reloads a wait that is still running.
    a_r7_load_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |-> !s_q.busy);

    // R7: expiry only ends a wait that was counting.
    a_r7_expire_from_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expired_o |-> $past(s_q.busy));

endmodule

// File: rtl/seq_mrs_offset.sv
module seq_mrs_offset #(
    parameter int             OFS_W  = 13,
    parameter logic [OFS_W-1:0] LO_CL3 = 13'h01D0,
    parameter logic [OFS_W-1:0] HI_CL3 = 13'h1E28,
    parameter logic [OFS_W-1:0] LO_CL2 = 13'h0150,
    parameter logic [OFS_W-1:0] HI_CL2 = 13'h1EA8
) (
    input  logic             cl2_i,
    input  logic             upper_i,
    output logic [OFS_W-1:0] ofs_o
);

    // Upper rows use the values with inverted address lines.
    always_comb begin
        case ({cl2_i, upper_i})
            2'b00:   ofs_o = LO_CL3;
            2'b01:   ofs_o = HI_CL3;
            2'b10:   ofs_o = LO_CL2;
            default: ofs_o = HI_CL2;
        endcase
    end

endmodule

// File: rtl/seq_row_scan.sv
module seq_row_scan
    import sdram_seq_pkg::*;
#(
    parameter int             NROWS     = 8,
    parameter int             BND_W     = 8,
    parameter int             ROW_SHIFT = 23,
    parameter int             OFS_W     = 13,
    parameter logic [OFS_W-1:0] LO_CL3  = 13'h01D0,
    parameter logic [OFS_W-1:0] HI_CL3  = 13'h1E28,
    parameter logic [OFS_W-1:0] LO_CL2  = 13'h0150,
    parameter logic [OFS_W-1:0] HI_CL2  = 13'h1EA8,
    localparam int            ROW_W     = (NROWS > 1) ? $clog2(NROWS) : 1,
    localparam int            ADDR_W    = BND_W + ROW_SHIFT
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   go_i,
    input  mode_e                  mode_i,
    input  logic                   cl2_i,
    input  logic [NROWS*BND_W-1:0] bounds_i,
    output logic                   strobe_o,
    output logic [ROW_W-1:0]       row_o,
    output logic [ADDR_W-1:0]      addr_o,
    output logic                   end_o
);

    localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(NROWS - 1);
    localparam logic [ROW_W-1:0] HALF_ROWS = ROW_W'(NROWS / 2);

    typedef struct packed {
        logic              active;
        logic              second;
        logic [ROW_W-1:0]  idx;
        logic              strobe;
        logic [ROW_W-1:0]  row;
        logic [ADDR_W-1:0] addr;
        logic              fin;
    } scan_t;

    scan_t s_d, s_q;

    logic [BND_W-1:0] row_base [NROWS];
    logic [NROWS-1:0] row_used;

    // Start of each row and whether it holds memory.
    for (genvar g = 0; g < NROWS; g++) begin : g_rows
        if (g == 0) begin : g_first
            assign row_base[g] = '0;
        end else begin : g_next
            assign row_base[g] = bounds_i[(g-1)*BND_W +: BND_W];
        end
        assign row_used[g] = bounds_i[g*BND_W +: BND_W] > row_base[g];
    end

    logic [BND_W-1:0]  cur_base;
    logic              cur_used;
    logic              upper_half;
    logic [OFS_W-1:0]  mrs_ofs;
    logic [OFS_W-1:0]  ofs_sel;
    logic [ADDR_W-1:0] cur_addr;

    assign cur_base   = row_base[s_q.idx];
    assign cur_used   = row_used[s_q.idx];
    assign upper_half = (s_q.idx >= HALF_ROWS);

    seq_mrs_offset #(
        .OFS_W  (OFS_W),
        .LO_CL3 (LO_CL3),
        .HI_CL3 (HI_CL3),
        .LO_CL2 (LO_CL2),
        .HI_CL2 (HI_CL2)
    ) ofs_i (
        .cl2_i   (cl2_i),
        .upper_i (upper_half),
        .ofs_o   (mrs_ofs)
    );

    assign ofs_sel  = (mode_i == MODE_MRS) ? mrs_ofs : '0;
    assign cur_addr = {cur_base, {ROW_SHIFT{1'b0}}} + ADDR_W'(ofs_sel);

    // Two cycles per row: an issue slot, then an advance slot.
    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        s_d.fin    = 1'b0;
        if (!s_q.active) begin
            if (go_i) begin
                s_d.active = 1'b1;
                s_d.second = 1'b0;
                s_d.idx    = '0;
            end
        end else if (!s_q.second) begin
            s_d.second = 1'b1;
            if (cur_used) begin
                s_d.strobe = 1'b1;
                s_d.row    = s_q.idx;
                s_d.addr   = cur_addr;
            end
        end else begin
            s_d.second = 1'b0;
            if (s_q.idx == LAST_ROW) begin
                s_d.active = 1'b0;
                s_d.fin    = 1'b1;
            end else begin
                s_d.idx = s_q.idx + ROW_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign strobe_o = s_q.strobe;
    assign row_o    = s_q.row;
    assign addr_o   = s_q.addr;
    assign end_o    = s_q.fin;

    // R6: strobes are isolated pulses.
    a_r6_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |=> !strobe_o);

    // R3: a new scan is only requested once the previous one has ended.
    a_r3_go_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i |-> !s_q.active);

    // R3: the end marker follows an active scan.
    a_r3_end_after_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
        end_o |-> $past(s_q.active));

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_seq_pkg::*;
#(
    parameter int             NROWS     = 8,
    parameter int             BND_W     = 8,
    parameter int             ROW_SHIFT = 23,
    parameter int             CYC_W     = 16,
    parameter int             US_W      = 8,
    parameter int             PWR_US    = 200,
    parameter int             NOP_US    = 200,
    parameter int             PRE_US    = 1,
    parameter int             CBR_US    = 1,
    parameter int             CBR_REPS  = 8,
    parameter int             MRS_US    = 2,
    parameter int             NORM_US   = 1,
    parameter int             OFS_W     = 13,
    parameter logic [OFS_W-1:0] LO_CL3  = 13'h01D0,
    parameter logic [OFS_W-1:0] HI_CL3  = 13'h1E28,
    parameter logic [OFS_W-1:0] LO_CL2  = 13'h0150,
    parameter logic [OFS_W-1:0] HI_CL2  = 13'h1EA8,
    localparam int            ROW_W     = (NROWS > 1) ? $clog2(NROWS) : 1,
    localparam int            ADDR_W    = BND_W + ROW_SHIFT,
    localparam int            REP_W     = $clog2(CBR_REPS + 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic [NROWS*BND_W-1:0] row_bound_i,
    input  logic                   cas_lat2_i,
    input  logic [CYC_W-1:0]       us_cycles_i,
    output logic [2:0]             cmd_o,
    output logic                   cmd_vld_o,
    output logic [ROW_W-1:0]       row_o,
    output logic [ADDR_W-1:0]      addr_o,
    output logic                   done_o,
    output logic                   refresh_en_o
);

    localparam logic [REP_W-1:0] LAST_REP = REP_W'(CBR_REPS - 1);

    typedef struct packed {
        phase_e           phase;
        mode_e            mode;
        logic [REP_W-1:0] reps;
        logic             go;
        logic             done;
        logic             refresh;
    } ctl_t;

    ctl_t s_d, s_q;

    logic            tmr_load;
    logic [US_W-1:0] tmr_us;
    logic            tmr_exp;
    logic            scan_end;

    // Wait that follows the scan of each mode.
    function automatic logic [US_W-1:0] wait_after(mode_e m);
        case (m)
            MODE_NOP:    return US_W'(NOP_US);
            MODE_PRECHG: return US_W'(PRE_US);
            MODE_CBR:    return US_W'(CBR_US);
            default:     return US_W'(MRS_US);
        endcase
    endfunction

    always_comb begin
        s_d      = s_q;
        s_d.go   = 1'b0;
        tmr_load = 1'b0;
        tmr_us   = '0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_PWR_WAIT;
                    tmr_load  = 1'b1;
                    tmr_us    = US_W'(PWR_US);
                end
            end
            PH_PWR_WAIT: begin
                if (tmr_exp) begin
                    s_d.mode  = MODE_NOP;
                    s_d.phase = PH_SCAN;
                    s_d.go    = 1'b1;
                end
            end
            PH_SCAN: begin
                if (scan_end) begin
                    s_d.phase = PH_WAIT;
                    tmr_load  = 1'b1;
                    tmr_us    = wait_after(s_q.mode);
                end
            end
            PH_WAIT: begin
                if (tmr_exp) begin
                    s_d.phase = PH_SCAN;
                    s_d.go    = 1'b1;
                    case (s_q.mode)
                        MODE_NOP: s_d.mode = MODE_PRECHG;
                        MODE_PRECHG: begin
                            s_d.mode = MODE_CBR;
                            s_d.reps = '0;
                        end
                        MODE_CBR: begin
                            if (s_q.reps == LAST_REP) s_d.mode = MODE_MRS;
                            else                      s_d.reps = s_q.reps + REP_W'(1);
                        end
                        default: begin
                            // Mode-register load done: normal mode, no row commands.
                            s_d.mode  = MODE_NORMAL;
                            s_d.phase = PH_NORM_WAIT;
                            s_d.go    = 1'b0;
                            tmr_load  = 1'b1;
                            tmr_us    = US_W'(NORM_US);
                        end
                    endcase
                end
            end
            PH_NORM_WAIT: begin
                if (tmr_exp) begin
                    s_d.phase   = PH_DONE;
                    s_d.done    = 1'b1;
                    s_d.refresh = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.phase   <= PH_IDLE;
            s_q.mode    <= MODE_NORMAL;
            s_q.reps    <= '0;
            s_q.go      <= 1'b0;
            s_q.done    <= 1'b0;
            s_q.refresh <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    seq_us_timer #(
        .US_W  (US_W),
        .CYC_W (CYC_W)
    ) tmr_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_i       (tmr_load),
        .us_i         (tmr_us),
        .cyc_per_us_i (us_cycles_i),
        .expired_o    (tmr_exp)
    );

    seq_row_scan #(
        .NROWS     (NROWS),
        .BND_W     (BND_W),
        .ROW_SHIFT (ROW_SHIFT),
        .OFS_W     (OFS_W),
        .LO_CL3    (LO_CL3),
        .HI_CL3    (HI_CL3),
        .LO_CL2    (LO_CL2),
        .HI_CL2    (HI_CL2)
    ) scan_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .go_i     (s_q.go),
        .mode_i   (s_q.mode),
        .cl2_i    (cas_lat2_i),
        .bounds_i (row_bound_i),
        .strobe_o (cmd_vld_o),
        .row_o    (row_o),
        .addr_o   (addr_o),
        .end_o    (scan_end)
    );

    assign cmd_o        = s_q.mode;
    assign done_o       = s_q.done;
    assign refresh_en_o = s_q.refresh;

    // R2: every strobe carries a row command, never normal mode.
    a_r2_strobe_not_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_vld_o |-> (cmd_o != 3'b000));

    // R2: the mode does not change under a strobe.
    a_r2_mode_stable_at_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_vld_o |-> $stable(cmd_o));

    // R2: reserved codes never appear.
    a_r2_no_reserved_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o <= 3'b100);

    // R8: completion is sticky and in normal mode.
    a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> done_o);

    a_r8_done_in_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (cmd_o == 3'b000) && refresh_en_o);

    // R9: nothing is issued after completion, even with start requests.
    a_r9_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && start_i) |=> (done_o && !cmd_vld_o));

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] row_bound_i = '0;
    logic        cas_lat2_i = 1'b0;
    logic [15:0] us_cycles_i = 16'd4;
    logic [2:0]  cmd_o;
    logic        cmd_vld_o;
    logic [2:0]  row_o;
    logic [30:0] addr_o;
    logic        done_o;
    logic        refresh_en_o;

    always #2 clk = ~clk;  // 250 MHz

    sdram_pwrup_seq dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start_i),
        .row_bound_i  (row_bound_i),
        .cas_lat2_i   (cas_lat2_i),
        .us_cycles_i  (us_cycles_i),
        .cmd_o        (cmd_o),
        .cmd_vld_o    (cmd_vld_o),
        .row_o        (row_o),
        .addr_o       (addr_o),
        .done_o       (done_o),
        .refresh_en_o (refresh_en_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Strobe log, written only by the monitor.
    int      cyc = 0;
    int      log_n = 0;
    logic [2:0]  log_cmd [256];
    logic [2:0]  log_row [256];
    logic [30:0] log_addr[256];
    int      log_cyc [256];
    int      norm_cyc = 0;
    int      done_cyc = 0;
    logic [2:0] prev_cmd = 3'b000;
    logic       prev_done = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && cmd_vld_o && log_n < 256) begin
            log_cmd[log_n]  = cmd_o;
            log_row[log_n]  = row_o;
            log_addr[log_n] = addr_o;
            log_cyc[log_n]  = cyc;
            log_n = log_n + 1;
        end
        if (rst_n && prev_cmd != 3'b000 && cmd_o == 3'b000 && !done_o) norm_cyc = cyc;
        if (rst_n && done_o && !prev_done) done_cyc = cyc;
        prev_cmd  = cmd_o;
        prev_done = done_o;
    end

    // Expected strobe list.
    int          exp_n;
    logic [2:0]  exp_cmd [128];
    logic [2:0]  exp_row [128];
    longint      exp_addr[128];
    int          exp_grp [128];

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
    endtask

    function automatic int wait_us_of(input int grp);
        if (grp == 0)  return 200;
        if (grp == 10) return 2;
        return 1;
    endfunction

    task automatic build_expected(input logic [63:0] bnd, input logic cl2);
        exp_n = 0;
        for (int g = 0; g < 11; g++) begin
            logic [2:0] c;
            c = (g == 0) ? 3'b001 : (g == 1) ? 3'b010 : (g <= 9) ? 3'b100 : 3'b011;
            for (int r = 0; r < 8; r++) begin
                int st;
                int en;
                longint ofs;
                st = (r == 0) ? 0 : int'(bnd[(r-1)*8 +: 8]);
                en = int'(bnd[r*8 +: 8]);
                if (en > st) begin
                    ofs = 0;
                    if (c == 3'b011)
                        ofs = cl2 ? ((r < 4) ? 64'h150 : 64'h1EA8)
                                  : ((r < 4) ? 64'h1D0 : 64'h1E28);
                    exp_cmd[exp_n]  = c;
                    exp_row[exp_n]  = 3'(r);
                    exp_addr[exp_n] = (longint'(st) << 23) + ofs;
                    exp_grp[exp_n]  = g;
                    exp_n = exp_n + 1;
                end
            end
        end
    endtask

    // Runs one complete sequence and compares it with the list built from the requirements.
    task automatic run_case(input string name, input logic [63:0] bnd, input logic cl2,
                            input int us, input bit hold_start);
        int base;
        int got;
        int uu;
        int start_cyc;
        int lim;
        row_bound_i = bnd;
        cas_lat2_i  = cl2;
        us_cycles_i = 16'(us);
        uu = (us == 0) ? 1 : us;
        do_reset();
        build_expected(bnd, cl2);
        base = log_n;
        start_i = 1'b1;
        start_cyc = cyc;
        @(negedge clk); #1;
        if (!hold_start) start_i = 1'b0;
        lim = 0;
        while (!done_o && lim < 60000) begin
            @(negedge clk); #1;
            lim = lim + 1;
        end
        @(negedge clk); #1;
        start_i = 1'b0;
        got = log_n - base;
        $display("case %s: %0d strobes", name, got);
        // R3: one strobe per populated row per command
        chk(got == exp_n, {name, " R3 strobe count"}, got, exp_n);
        for (int k = 0; k < exp_n && k < got; k++) begin
            chk(log_cmd[base+k] == exp_cmd[k], {name, " R2 command order"}, log_cmd[base+k], exp_cmd[k]);
            chk(log_row[base+k] == exp_row[k], {name, " R3 row index"}, log_row[base+k], exp_row[k]);
            if (exp_cmd[k] == 3'b011)
                chk(longint'(log_addr[base+k]) == exp_addr[k], {name, " R5 MRS address"},
                    log_addr[base+k], exp_addr[k]);
            else
                chk(longint'(log_addr[base+k]) == exp_addr[k], {name, " R4 row base address"},
                    log_addr[base+k], exp_addr[k]);
            if (k > 0 && exp_grp[k] != exp_grp[k-1]) begin
                int gap;
                int need;
                gap  = log_cyc[base+k] - log_cyc[base+k-1];
                need = wait_us_of(exp_grp[k-1]) * uu;
                chk(gap >= need && gap <= need + 48, {name, " R7 wait between commands"}, gap, need);
            end
            if (k > 0)
                chk(log_cyc[base+k] - log_cyc[base+k-1] >= 2, {name, " R6 strobe spacing"},
                    log_cyc[base+k] - log_cyc[base+k-1], 2);
        end
        if (exp_n > 0 && got > 0) begin
            chk(log_cyc[base] - start_cyc >= 200 * uu, {name, " R7 power-up wait"},
                log_cyc[base] - start_cyc, 200 * uu);
            chk(norm_cyc - log_cyc[base+got-1] >= 2 * uu, {name, " R8 normal after MRS wait"},
                norm_cyc - log_cyc[base+got-1], 2 * uu);
        end
        chk(done_o == 1'b1, {name, " R8 done raised"}, done_o, 1);
        chk(refresh_en_o == 1'b1, {name, " R8 refresh enabled"}, refresh_en_o, 1);
        chk(cmd_o == 3'b000, {name, " R8 normal mode at end"}, cmd_o, 0);
        chk(done_cyc - norm_cyc >= uu, {name, " R8 final wait"}, done_cyc - norm_cyc, uu);
        chk(done_cyc - start_cyc >= 412 * uu, {name, " R7 total duration"}, done_cyc - start_cyc, 412 * uu);
    endtask

    task automatic t_reset();
        int base;
        row_bound_i = 64'h1008_0604_0302_0100;
        us_cycles_i = 16'd4;
        do_reset();
        chk(cmd_o == 3'b000, "R1 reset mode", cmd_o, 0);
        chk(cmd_vld_o == 1'b0, "R1 reset strobe", cmd_vld_o, 0);
        chk(done_o == 1'b0, "R1 reset done", done_o, 0);
        chk(refresh_en_o == 1'b0, "R1 reset refresh", refresh_en_o, 0);
        base = log_n;
        repeat (1000) @(negedge clk);
        #1;
        chk(log_n == base, "R1 idle without start", log_n - base, 0);
        chk(done_o == 1'b0, "R1 no completion without start", done_o, 0);
    endtask

    task automatic t_after_done();
        int base;
        base = log_n;
        @(negedge clk); #1 start_i = 1'b1;
        @(negedge clk); #1 start_i = 1'b0;
        repeat (2000) @(negedge clk);
        #1;
        chk(log_n == base, "R9 start after done issues nothing", log_n - base, 0);
        chk(done_o == 1'b1, "R9 done held after start", done_o, 1);
        chk(refresh_en_o == 1'b1, "R8 refresh held", refresh_en_o, 1);
    endtask

    initial begin
        t_reset();
        // All rows populated, CAS latency 3.
        run_case("full_cl3", 64'h100C_0806_0403_0201, 1'b0, 4, 1'b0);
        t_after_done();
        // Rows 1, 3, 6 populated, row 0 empty, CAS latency 3.
        run_case("sparse_cl3", 64'h0909_0505_0502_0200, 1'b0, 3, 1'b0);
        // Rows 0, 4, 7 populated, CAS latency 2, start held for the whole run (R9).
        run_case("mixed_cl2_held", 64'h1008_0808_0404_0404, 1'b1, 4, 1'b1);
        // No rows populated, zero cycle count treated as one.
        run_case("empty_us0", 64'h0, 1'b1, 0, 1'b0);
        summary();
        $finish;
    end

endmodule